// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small number of recent page translations so that a virtual page number can be turned into a physical page number without walking the page table in memory. Each entry holds a physical page number and a few permission bits. With the default parameters there are 16 entries in 4 sets of 4 ways. The two low bits of the 8-bit virtual page number choose the set, and the six high bits are compared as the tag. Only page numbers are presented to the block: byte offsets inside a page never reach it.

A lookup is answered in the same cycle it is presented. After a page walk, the walker loads a translation through the fill port, and the translation can be looked up from the next cycle. A fill takes a free way of its set if one exists. If the set is full, it replaces the least recently used way, where both fills and lookup hits count as uses. On a process switch one flush input clears every entry at once.

Top module: `xlat_tlb`

## Requirements
- R1: Bits [1:0] of the virtual page number select one of 4 sets and bits [7:2] are the tag. A page number that differs from a stored one only in the set bits misses.
- R2: When `lk_valid` is high and the selected set holds a valid entry with an equal tag, `lk_hit` is 1 in that same cycle and `lk_ppn`/`lk_perm` carry that entry's stored values. `lk_hit` is 0 whenever `lk_valid` is 0.
- R3: When there is no hit, `lk_hit`, `lk_ppn` and `lk_perm` are all 0.
- R4: A fill that is not flushed can be looked up from the next cycle onward with the filled values. Entries in other sets and other ways keep their contents.
- R5: A fill whose tag is not present goes to the lowest-numbered invalid way of its set, so a set holds up to 4 different tags at once.
- R6: A fill into a full set with a new tag replaces the way whose last use (fill or lookup hit) is oldest.
- R7: A lookup hit counts as a use of that way, so a refreshed way is not the next one replaced.
- R8: A fill whose tag is already valid in its set overwrites that way in place. No other entry is lost and no duplicate tag exists.
- R9: A flush clears every entry in one cycle. From the next cycle every lookup misses until new fills arrive.
- R10: When flush and fill occur in the same cycle, the fill is dropped and the flush is applied.
- R11: After reset every entry is invalid and every lookup misses.
- R12: A lookup in the same cycle as a fill sees the contents from before the fill. If both touch the same set, the lookup hit counts as a use before the fill picks its way, and the filled way becomes the most recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 8 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found (same cycle) |
| lk_ppn | output | 6 | Physical page number of the hit, 0 on a miss |
| lk_perm | output | 2 | Permission bits of the hit, 0 on a miss |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | 8 | Virtual page number of the translation |
| fill_ppn | input | 6 | Physical page number to store |
| fill_perm | input | 2 | Permission bits to store |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Lookup results are combinational from stored state, so they are due in the cycle of the request. The bench drives each request on the falling edge and samples 1 ns later, which is before the rising edge that commits any fill, flush or recency change. The effects of a fill or flush are due from the cycle after that rising edge, so the bench checks them only with lookups issued on later falling edges. Its reference model advances at the same boundary: it settles the lookup against the old state first, and only then applies the cycle's updates.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
   localparam int unsigned DEF_VPN_W    = 8;
   localparam int unsigned DEF_SET_BITS = 2;
   localparam int unsigned DEF_WAYS     = 4;
   localparam int unsigned DEF_PPN_W    = 6;
   localparam int unsigned DEF_PERM_W   = 2;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/xlat_tlb_age.sv
module xlat_tlb_age #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_touch,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_touch,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAY_W-1:0] victim
);
   logic [WAY_W-1:0] age_q   [WAYS];
   logic [WAY_W-1:0] age_mid [WAYS];
   logic [WAY_W-1:0] age_nxt [WAYS];

   // the lookup hit ages the other ways first; the victim is chosen after it
   always_comb begin
      age_mid = age_q;
      if (hit_touch) begin
         for (int w = 0; w < WAYS; w++)
            if (age_q[w] < age_q[hit_way]) age_mid[w] = age_q[w] + WAY_W'(1);
         age_mid[hit_way] = '0;
      end
   end

   always_comb begin
      victim = '0;
      for (int w = 0; w < WAYS; w++)
         if (age_mid[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
   end

   always_comb begin
      age_nxt = age_mid;
      if (fill_touch) begin
         for (int w = 0; w < WAYS; w++)
            if (age_mid[w] < age_mid[fill_way]) age_nxt[w] = age_mid[w] + WAY_W'(1);
         age_nxt[fill_way] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
      end else begin
         age_q <= age_nxt;
      end
   end
endmodule

// File: rtl/xlat_tlb_set.sv
module xlat_tlb_set #(
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned PPN_W  = 6,
   parameter int unsigned PERM_W = 2,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned WAY_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_sel,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic [WAYS-1:0]   lk_match,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fl_sel,
   input  logic [TAG_W-1:0]  fl_tag,
   input  logic [PPN_W-1:0]  fl_ppn,
   input  logic [PERM_W-1:0] fl_perm
);
   logic [WAYS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [WAYS];
   logic [PPN_W-1:0]  ppn_q  [WAYS];
   logic [PERM_W-1:0] perm_q [WAYS];
   logic [WAYS-1:0]   fl_match;
   logic [WAY_W-1:0]  hit_way, fill_way, victim;
   logic              wr_en, hit_touch;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign lk_match[w] = lk_sel && valid_q[w] && (tag_q[w] == lk_tag);
      assign fl_match[w] = valid_q[w] && (tag_q[w] == fl_tag);
   end

   always_comb begin
      hit_way = '0;
      lk_ppn  = '0;
      lk_perm = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_match[w]) begin
            hit_way = WAY_W'(w);
            lk_ppn  = lk_ppn | ppn_q[w];
            lk_perm = lk_perm | perm_q[w];
         end
      end
   end

   // existing tag first, then lowest free way, then the oldest way
   always_comb begin
      fill_way = victim;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!valid_q[w]) fill_way = WAY_W'(w);
      for (int w = 0; w < WAYS; w++)
         if (fl_match[w]) fill_way = WAY_W'(w);
   end

   assign wr_en     = fl_sel && !flush;
   assign hit_touch = !flush && (|lk_match);

   xlat_tlb_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_touch  (hit_touch),
      .hit_way    (hit_way),
      .fill_touch (wr_en),
      .fill_way   (fill_way),
      .victim     (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) valid_q <= '0;
      else if (wr_en)      valid_q[fill_way] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[fill_way]  <= fl_tag;
         ppn_q[fill_way]  <= fl_ppn;
         perm_q[fill_way] <= fl_perm;
      end
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_tlb_pkg::*;
#(
   parameter int unsigned VPN_W    = DEF_VPN_W,
   parameter int unsigned SET_BITS = DEF_SET_BITS,
   parameter int unsigned WAYS     = DEF_WAYS,
   parameter int unsigned PPN_W    = DEF_PPN_W,
   parameter int unsigned PERM_W   = DEF_PERM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              flush_all
);
   localparam int unsigned SETS  = 1 << SET_BITS;
   localparam int unsigned TAG_W = VPN_W - SET_BITS;
   localparam int unsigned WAY_W = idx_bits(WAYS);

   if (SET_BITS < 1 || SET_BITS >= VPN_W) begin : g_bad_index
      $error("xlat_tlb: SET_BITS must lie in 1..VPN_W-1");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("xlat_tlb: WAYS must be a power of two, at least 2");
   end
   if (PPN_W < 1 || PERM_W < 1) begin : g_bad_data
      $error("xlat_tlb: PPN_W and PERM_W must be at least 1");
   end

   logic [SET_BITS-1:0]          lk_idx, fl_idx;
   logic [TAG_W-1:0]             lk_tag, fl_tag;
   logic [SETS-1:0][WAYS-1:0]    set_match;
   logic [SETS-1:0][PPN_W-1:0]   set_ppn;
   logic [SETS-1:0][PERM_W-1:0]  set_perm;
   logic [SETS*WAYS-1:0]         set_match_flat;

   assign lk_idx = lk_vpn[SET_BITS-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];
   assign fl_idx = fill_vpn[SET_BITS-1:0];
   assign fl_tag = fill_vpn[VPN_W-1:SET_BITS];
   assign set_match_flat = set_match;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      xlat_tlb_set #(
         .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W),
         .WAYS(WAYS), .WAY_W(WAY_W)
      ) u_set (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush_all),
         .lk_sel   (lk_valid && (lk_idx == SET_BITS'(s))),
         .lk_tag   (lk_tag),
         .lk_match (set_match[s]),
         .lk_ppn   (set_ppn[s]),
         .lk_perm  (set_perm[s]),
         .fl_sel   (fill_valid && (fl_idx == SET_BITS'(s))),
         .fl_tag   (fl_tag),
         .fl_ppn   (fill_ppn),
         .fl_perm  (fill_perm)
      );
   end

   always_comb begin
      lk_ppn  = '0;
      lk_perm = '0;
      for (int s = 0; s < SETS; s++) begin
         lk_ppn  = lk_ppn | set_ppn[s];
         lk_perm = lk_perm | set_perm[s];
      end
   end

   assign lk_hit = |set_match_flat;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int unsigned VPN_W   = 8,
   parameter int unsigned PPN_W   = 6,
   parameter int unsigned PERM_W  = 2,
   parameter int unsigned MATCH_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic               lk_hit,
   input logic [PPN_W-1:0]   lk_ppn,
   input logic [PERM_W-1:0]  lk_perm,
   input logic               fill_valid,
   input logic [VPN_W-1:0]   fill_vpn,
   input logic [PPN_W-1:0]   fill_ppn,
   input logic [PERM_W-1:0]  fill_perm,
   input logic               flush_all,
   input logic [MATCH_W-1:0] set_match
);
   AST_NO_REQ_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit); // R2

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppn == '0 && lk_perm == '0)); // R3

   AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_match)); // R8

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !lk_hit); // R9

   AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush_all) |=>
         (!(lk_valid && lk_vpn == $past(fill_vpn)) ||
          (lk_hit && lk_ppn == $past(fill_ppn) && lk_perm == $past(fill_perm)))); // R4

   AST_STABLE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !fill_valid && !flush_all) |=>
         (!(lk_valid && lk_vpn == $past(lk_vpn)) ||
          (lk_hit == $past(lk_hit) && lk_ppn == $past(lk_ppn)))); // R2
endmodule

bind xlat_tlb xlat_tlb_chk #(
   .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .MATCH_W(SETS * WAYS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_vpn     (lk_vpn),
   .lk_hit     (lk_hit),
   .lk_ppn     (lk_ppn),
   .lk_perm    (lk_perm),
   .fill_valid (fill_valid),
   .fill_vpn   (fill_vpn),
   .fill_ppn   (fill_ppn),
   .fill_perm  (fill_perm),
   .flush_all  (flush_all),
   .set_match  (set_match_flat)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lk_valid = 1'b0;
   logic [7:0] lk_vpn = '0;
   logic       lk_hit;
   logic [5:0] lk_ppn;
   logic [1:0] lk_perm;
   logic       fill_valid = 1'b0;
   logic [7:0] fill_vpn = '0;
   logic [5:0] fill_ppn = '0;
   logic [1:0] fill_perm = '0;
   logic       flush_all = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model: last-use stamps instead of age counters
   bit         m_valid [4][4];
   logic [5:0] m_tag   [4][4];
   logic [5:0] m_ppn   [4][4];
   logic [1:0] m_perm  [4][4];
   int         m_stamp [4][4];
   int         now = 0;
   logic [31:0] rng = 32'h1234_5677;

   always #5 clk = ~clk;

   xlat_tlb dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .flush_all(flush_all)
   );

   function automatic logic [5:0] f_ppn(input logic [7:0] v);
      return 6'(v * 5 + 3);
   endfunction
   function automatic logic [1:0] f_perm(input logic [7:0] v);
      return v[3:2] ^ v[6:5];
   endfunction
   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   task automatic op(input bit lv, input logic [7:0] lvpn,
                     input bit fv, input logic [7:0] fvpn,
                     input logic [5:0] fppn, input logic [1:0] fperm,
                     input bit fl, input string req);
      bit         eh;
      logic [5:0] ep;
      logic [1:0] eperm;
      int         hw, s, fw, old;
      @(negedge clk);
      lk_valid = lv; lk_vpn = lvpn;
      fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
      flush_all = fl;
      #1;
      eh = 1'b0; ep = '0; eperm = '0; hw = 0;
      s = int'(lvpn[1:0]);
      for (int w = 0; w < 4; w++)
         if (lv && m_valid[s][w] && m_tag[s][w] == lvpn[7:2]) begin
            eh = 1'b1; ep = m_ppn[s][w]; eperm = m_perm[s][w]; hw = w;
         end
      if (lv) begin
         n_checks++;
         if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== eperm) begin
            n_fail++;
            $display("FAIL %s vpn=%02h got hit=%0b ppn=%02h perm=%0d exp hit=%0b ppn=%02h perm=%0d",
                     req, lvpn, lk_hit, lk_ppn, lk_perm, eh, ep, eperm);
         end
      end
      if (fl) begin
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) m_valid[a][b] = 1'b0;
      end else begin
         if (eh) begin now++; m_stamp[s][hw] = now; end
         if (fv) begin
            s = int'(fvpn[1:0]);
            fw = -1;
            for (int w = 0; w < 4; w++)
               if (m_valid[s][w] && m_tag[s][w] == fvpn[7:2]) fw = w;
            if (fw < 0)
               for (int w = 3; w >= 0; w--) if (!m_valid[s][w]) fw = w;
            if (fw < 0) begin
               fw = 0; old = m_stamp[s][0];
               for (int w = 1; w < 4; w++)
                  if (m_stamp[s][w] < old) begin fw = w; old = m_stamp[s][w]; end
            end
            m_valid[s][fw] = 1'b1; m_tag[s][fw] = fvpn[7:2];
            m_ppn[s][fw] = fppn; m_perm[s][fw] = fperm;
            now++; m_stamp[s][fw] = now;
         end
      end
   endtask

   task automatic look(input logic [7:0] v, input string req);
      op(1'b1, v, 1'b0, 8'h00, 6'h00, 2'b00, 1'b0, req);
   endtask
   task automatic fill(input logic [7:0] v);
      op(1'b0, 8'h00, 1'b1, v, f_ppn(v), f_perm(v), 1'b0, "fill");
   endtask
   task automatic sweep(input string req);
      for (int v = 0; v < 256; v++) look(8'(v), req);
   endtask
   task automatic probe_set(input int s, input int tmax, input string req);
      for (int t = 0; t <= tmax; t++) look({6'(t), 2'(s)}, req);
   endtask

   initial begin
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++) begin
            m_valid[a][b] = 1'b0; m_stamp[a][b] = 0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      sweep("R11");                         // everything misses after reset, R3 too

      // tags s*4+1 .. s*4+4 in each set, way order 0..3
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 4; w++) fill({6'(s * 4 + w + 1), 2'(s)});
      sweep("R5");

      look({6'd1, 2'd1}, "R1");             // tag of set 0 presented to set 1
      look({6'd5, 2'd0}, "R1");
      look({6'd5, 2'd1}, "R1");

      // R8: refill an existing tag with new data
      op(1'b0, 8'h00, 1'b1, {6'd6, 2'd1}, 6'h3F, 2'b11, 1'b0, "fill");
      probe_set(1, 10, "R8");

      // R6: set 2 uses 12, 9, 10 so 11 is oldest
      look({6'd12, 2'd2}, "R6"); look({6'd9, 2'd2}, "R6"); look({6'd10, 2'd2}, "R6");
      fill({6'd40, 2'd2});
      probe_set(2, 41, "R6");
      // R7: refresh 12, next new tag must take 9 instead
      look({6'd12, 2'd2}, "R7");
      fill({6'd41, 2'd2});
      probe_set(2, 41, "R7");

      // R12: lookup of tag 1 and fill of tag 50 in set 0, same cycle
      op(1'b1, {6'd1, 2'd0}, 1'b1, {6'd50, 2'd0}, f_ppn({6'd50, 2'd0}),
         f_perm({6'd50, 2'd0}), 1'b0, "R12");
      op(1'b1, {6'd50, 2'd0}, 1'b1, {6'd51, 2'd3}, f_ppn({6'd51, 2'd3}),
         f_perm({6'd51, 2'd3}), 1'b0, "R12");
      probe_set(0, 50, "R12");

      // R4: a fill in set 3 leaves the others alone
      fill({6'd33, 2'd3});
      sweep("R4");

      // R10: flush and fill together, fill dropped
      op(1'b0, 8'h00, 1'b1, {6'd61, 2'd3}, 6'h11, 2'b01, 1'b1, "fill");
      look({6'd61, 2'd3}, "R10");
      sweep("R9");

      // mixed traffic over a small tag pool
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] lv8, fv8;
         bit         lvb, fvb, flb;
         rng = next_rng(rng);
         lvb = (rng[3:0] < 4'd11);
         fvb = (rng[7:4] < 4'd6);
         flb = (rng[13:8] == 6'd0);
         lv8 = {6'(rng[18:16] % 3'd6), rng[20:19]};
         fv8 = {6'(rng[24:22] % 3'd6), rng[26:25]};
         op(lvb, lv8, fvb, fv8, 6'(rng[31:27] ^ rng[5:0]), rng[15:14], flb,
            fvb ? "R12" : "R2");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(10 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule